// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one one-way DMA channel that sits beside a serial peripheral. Software loads a current buffer (a pointer and an item count) and, if it wants, a queued buffer. Each request strobe from the peripheral makes the channel do one memory access. In receive direction it writes the item the peripheral offered to memory. In transmit direction it reads an item from memory and hands it to the peripheral. After each access the pointer moves forward by the item size and the count goes down by one.

When the current count runs out, the channel raises an end-of-buffer flag. If a queued buffer is waiting, the channel switches to it at once and empties the queue slot, so streaming goes on without a gap. If nothing is queued, the channel raises a buffer-full flag (receive) or a buffer-empty flag (transmit) and then ignores requests. It stays that way until software writes a new non-zero current count.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset, both pointers and both counts are zero, no flag is raised, `mem_req` is low and `per_tx_valid` is low.
- R2: A register write selects its target by `reg_sel`: 0 is the current pointer, 1 the current count, 2 the queued pointer, 3 the queued count. Counts take the low 16 bits of `reg_wdata`. Writes to the current pair are ignored while a memory access is in flight.
- R3: With `cfg_tx`=0 (receive), a request accepted while the current count is non-zero raises `mem_req` with `mem_we`=1. The address is the current pointer and `mem_wdata` is the `per_rx_data` sampled with the request.
- R4: With `cfg_tx`=1 (transmit), an accepted request raises `mem_req` with `mem_we`=0 at the current pointer. The cycle after `mem_ack`, `per_tx_valid` pulses and `per_tx_data` carries the `mem_rdata` returned with the ack.
- R5: Each completed access moves the current pointer forward by 1, 2 or 4 for `cfg_size` 0, 1 or 2 (a value of 3 acts as 2). Unless a reload happens, the current count drops by one.
- R6: While `mem_req` is high and `mem_ack` has not arrived, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R7: The access that brings the current count to zero sets `end_of_buf`. Any accepted write to a count clears it.
- R8: If that last access finds a non-zero queued count, the current pointer and count take the queued values and the queued count becomes zero. The next access uses the queued pointer.
- R9: If that last access finds the queued count zero, the current count stays zero. `buf_full` is raised if the last transfer was receive, and `buf_empty` if it was transmit.
- R10: A request arriving while idle with a zero current count produces no memory access and changes no count.
- R11: Writing a non-zero current count while idle clears `buf_full`/`buf_empty` and re-arms the channel for requests.
- R12: A request strobe arriving while an access is in flight is dropped; no second access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx | input | 1 | 0 receive (peripheral to memory), 1 transmit |
| cfg_size | input | 2 | Item size: 0 byte, 1 halfword, 2/3 word |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| per_req | input | 1 | Peripheral request strobe |
| per_rx_data | input | 32 | Item offered by the peripheral |
| per_tx_data | output | 32 | Item read for the peripheral |
| per_tx_valid | output | 1 | One-cycle pulse, `per_tx_data` valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| cur_ptr | output | 32 | Current pointer |
| cur_cnt | output | 16 | Current count |
| nxt_ptr | output | 32 | Queued pointer |
| nxt_cnt | output | 16 | Queued count |
| end_of_buf | output | 1 | Current buffer finished |
| buf_full | output | 1 | Receive ran out of buffers |
| buf_empty | output | 1 | Transmit ran out of buffers |

## Verification
The bench targets the last item of a buffer, both with and without a queued buffer. A design that got this wrong would chain the same queued buffer twice, keep the old pointer after a switch, or fail to stop and write past the buffer end. It pulses requests while the count is zero and while an access is in flight. A faulty design would then touch memory it does not own or start an extra access. It also holds `mem_ack` back for several cycles, which catches an address or data word that changes before the memory has taken it. Random runs mix the three item sizes and both directions, which catches a wrong pointer step or a full/empty flag raised for the wrong direction.

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan #(
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tx,
  input  logic [1:0]        cfg_size,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [PTR_W-1:0]  reg_wdata,
  input  logic              per_req,
  input  logic [DATA_W-1:0] per_rx_data,
  output logic [DATA_W-1:0] per_tx_data,
  output logic              per_tx_valid,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [PTR_W-1:0]  cur_ptr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [PTR_W-1:0]  nxt_ptr,
  output logic [CNT_W-1:0]  nxt_cnt,
  output logic              end_of_buf,
  output logic              buf_full,
  output logic              buf_empty
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              busy, dir_q, exhausted;
  logic [DATA_W-1:0] hold_q;
  logic [PTR_W-1:0]  step;
  logic [CNT_W-1:0]  wr_cnt;
  logic              start, done, last, chain, wr_cur;

  assign wr_cnt = reg_wdata[CNT_W-1:0];
  assign step   = (cfg_size == 2'd0) ? PTR_W'(1) :
                  (cfg_size == 2'd1) ? PTR_W'(2) : PTR_W'(4);
  assign start  = per_req && !busy && (cur_cnt != '0);
  assign done   = busy && mem_ack;
  assign last   = done && (cur_cnt == CNT_ONE);
  assign chain  = last && (nxt_cnt != '0);
  assign wr_cur = reg_we && !busy;

  assign mem_req   = busy;
  assign mem_we    = !dir_q;
  assign mem_addr  = cur_ptr;
  assign mem_wdata = hold_q;
  assign buf_full  = exhausted && !dir_q;
  assign buf_empty = exhausted && dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      dir_q        <= 1'b0;
      hold_q       <= '0;
      per_tx_data  <= '0;
      per_tx_valid <= 1'b0;
    end else begin
      per_tx_valid <= done && dir_q;
      if (start) begin
        busy   <= 1'b1;
        dir_q  <= cfg_tx;
        hold_q <= per_rx_data;
      end else if (done) begin
        busy <= 1'b0;
      end
      if (done && dir_q) per_tx_data <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ptr <= '0;
      cur_cnt <= '0;
    end else if (done) begin
      if (chain) begin
        cur_ptr <= nxt_ptr;
        cur_cnt <= nxt_cnt;
      end else begin
        cur_ptr <= cur_ptr + step;
        cur_cnt <= cur_cnt - CNT_ONE;
      end
    end else if (wr_cur && reg_sel == 2'd0) begin
      cur_ptr <= reg_wdata;
    end else if (wr_cur && reg_sel == 2'd1) begin
      cur_cnt <= wr_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_ptr <= '0;
      nxt_cnt <= '0;
    end else begin
      if (reg_we && reg_sel == 2'd2) nxt_ptr <= reg_wdata;
      if (reg_we && reg_sel == 2'd3) nxt_cnt <= wr_cnt;
      else if (chain)                nxt_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_of_buf <= 1'b0;
      exhausted  <= 1'b0;
    end else begin
      if (last)
        end_of_buf <= 1'b1;
      else if ((reg_we && reg_sel == 2'd3) || (wr_cur && reg_sel == 2'd1))
        end_of_buf <= 1'b0;
      if (last && !chain)
        exhausted <= 1'b1;
      else if (wr_cur && reg_sel == 2'd1 && wr_cnt != '0)
        exhausted <= 1'b0;
    end
  end

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_idle_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && cur_cnt == '0 && per_req && !reg_we |=> !mem_req && cur_cnt == '0);

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && cur_cnt > CNT_ONE |=>
      cur_cnt == CNT_W'($past(cur_cnt) - CNT_ONE) && cur_ptr == PTR_W'($past(cur_ptr) + $past(step)));

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && cur_cnt == CNT_ONE && nxt_cnt != '0 && !(reg_we && reg_sel == 2'd3) |=>
      cur_cnt == $past(nxt_cnt) && cur_ptr == $past(nxt_ptr) && nxt_cnt == '0 && end_of_buf);

  p_exhaust_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && cur_cnt == CNT_ONE && nxt_cnt == '0 && !(reg_we && reg_sel == 2'd3) |=>
      cur_cnt == '0 && (buf_full || buf_empty) && !mem_req);

  p_drop_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);
endmodule

// File: tb/dbuf_dma_chan_tb.sv
module dbuf_dma_chan_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_tx = 1'b0;
  logic [1:0]  cfg_size = 2'd2;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        per_req = 1'b0;
  logic [31:0] per_rx_data = '0;
  logic [31:0] per_tx_data;
  logic        per_tx_valid;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] cur_ptr, nxt_ptr;
  logic [15:0] cur_cnt, nxt_cnt;
  logic        end_of_buf, buf_full, buf_empty;

  int checks = 0, errors = 0;
  logic [31:0] m_cp = '0, m_np = '0;
  logic [15:0] m_cc = '0, m_nc = '0;
  logic        m_eob = 1'b0, m_exh = 1'b0, m_dir = 1'b0;

  always #10 clk = ~clk;

  dbuf_dma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx), .cfg_size(cfg_size),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .per_req(per_req), .per_rx_data(per_rx_data),
    .per_tx_data(per_tx_data), .per_tx_valid(per_tx_valid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .cur_ptr(cur_ptr), .cur_cnt(cur_cnt), .nxt_ptr(nxt_ptr), .nxt_cnt(nxt_cnt),
    .end_of_buf(end_of_buf), .buf_full(buf_full), .buf_empty(buf_empty));

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] inc(input logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " cur_ptr"}, cur_ptr, m_cp);
    check({req, " cur_cnt"}, cur_cnt, m_cc);
    check({req, " nxt_ptr"}, nxt_ptr, m_np);
    check({req, " nxt_cnt"}, nxt_cnt, m_nc);
    check({req, " end_of_buf"}, end_of_buf, m_eob);
    check({req, " buf_full"}, buf_full, m_exh && !m_dir);
    check({req, " buf_empty"}, buf_empty, m_exh && m_dir);
  endtask

  // R2 register write, bench only writes while idle
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      2'd0: m_cp = d;
      2'd1: begin m_cc = d[15:0]; m_eob = 1'b0; if (d[15:0] != 0) m_exh = 1'b0; end
      2'd2: m_np = d;
      default: begin m_nc = d[15:0]; m_eob = 1'b0; end
    endcase
  endtask

  // one request; poke=1 strobes a request and a current-count write mid-access (needs lat>=2)
  task automatic xfer(input int lat, input bit poke);
    logic [31:0] rx, exp_rd;
    rx = $urandom;
    @(negedge clk);
    per_req = 1'b1; per_rx_data = rx;
    @(negedge clk);
    per_req = 1'b0;
    if (m_cc == 0) begin
      check("R10 no access when empty", mem_req, 1'b0);
      check("R10 count untouched", cur_cnt, 16'd0);
      return;
    end
    m_dir = cfg_tx;
    check("R3/R4 mem_req", mem_req, 1'b1);
    check("R3/R4 mem_addr", mem_addr, m_cp);
    check("R3/R4 mem_we", mem_we, !cfg_tx);
    if (!cfg_tx) check("R3 write data", mem_wdata, rx);
    for (int i = 0; i < lat; i++) begin
      if (poke && i == 0) begin
        per_req = 1'b1; reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h7777;
      end
      @(negedge clk);
      per_req = 1'b0; reg_we = 1'b0;
      check("R6 request held", mem_req, 1'b1);
      check("R6 address held", mem_addr, m_cp);
      if (!cfg_tx) check("R6 data held", mem_wdata, rx);
    end
    exp_rd = pat(mem_addr);
    mem_ack = 1'b1; mem_rdata = exp_rd;
    @(negedge clk);
    mem_ack = 1'b0;
    if (m_cc == 1) begin
      m_eob = 1'b1;
      if (m_nc != 0) begin m_cp = m_np; m_cc = m_nc; m_nc = 0; end
      else begin m_cc = 0; m_exh = 1'b1; m_cp = m_cp + inc(cfg_size); end
    end else begin
      m_cp = m_cp + inc(cfg_size); m_cc = m_cc - 1;
    end
    check_state("R5/R7/R8/R9");
    check(poke ? "R12 dropped request" : "R12 single access", mem_req, 1'b0);
    check("R4 tx valid", per_tx_valid, cfg_tx);
    if (cfg_tx) check("R4 tx data", per_tx_data, exp_rd);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_state("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release");
    check("R1 mem_req", mem_req, 1'b0);
    check("R1 tx valid", per_tx_valid, 1'b0);

    // R10 empty channel ignores requests
    xfer(0, 0);
    check_state("R10 state");

    // R3 R8 R9: receive words, chain once, then run out
    cfg_tx = 1'b0; cfg_size = 2'd2;
    wr(2'd0, 32'h1000); wr(2'd1, 32'd3); wr(2'd2, 32'h2000); wr(2'd3, 32'd2);
    check_state("R2 writes");
    for (int k = 0; k < 5; k++) xfer(k % 3, 0);
    check("R9 buf_full raised", buf_full, 1'b1);
    xfer(1, 0);
    check_state("R10 after exhaustion");

    // R11 re-arm, R4 transmit bytes and halfwords, R12 drop, R2 busy write ignored
    cfg_tx = 1'b1; cfg_size = 2'd0;
    wr(2'd0, 32'h3001); wr(2'd1, 32'd4);
    check("R11 flag cleared", buf_full | buf_empty, 1'b0);
    xfer(3, 1);
    xfer(0, 0);
    cfg_size = 2'd1;
    xfer(2, 0);
    cfg_size = 2'd3;
    xfer(1, 0);
    check("R9 buf_empty raised", buf_empty, 1'b1);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom % 10;
      if (op < 6) xfer($urandom % 4, ($urandom % 8) == 0);
      else if (op == 6) begin wr(2'd2, $urandom); wr(2'd3, $urandom % 4); end
      else if (op == 7) begin wr(2'd0, $urandom); wr(2'd1, $urandom % 5); end
      else begin
        @(negedge clk);
        cfg_tx = $urandom; cfg_size = $urandom;
      end
    end
    @(negedge clk);
    check_state("R5/R8 random end");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule